// File: doc/BRIEF.md
# Dual-Clock FIFO with Load-Mode Thresholds

This block is a first-in first-out buffer. Its write side and its read side run on two independent clocks. Words enter on the write clock and leave through a registered output on the read clock. Four active-low status outputs report the fill state: empty, full, nearly empty and nearly full. The two "nearly" thresholds come from two offset buses, which the surrounding logic loads and holds. A separate sequencer, outside this block, fills those buses. The usual value for both offsets is 7.

The input `wen2_ld` has two uses, and the level it holds during reset picks which one applies until the next reset:

- **Two-enable mode** (pin high during reset): the pin is a second, active-high write enable.
- **Load mode** (pin low during reset): the offset interface owns the ports while the pin is low. Both normal writes and normal reads are then suppressed.

The read pointer and the write pointer cross between clock domains as Gray code through two-stage synchronizers. Each flag is computed from the far pointer as it appears after synchronization. A flag can therefore lag in the safe direction, but it never reports room or data that does not exist.

Top module: `twin_clock_fifo`

## Requirements
- R1: A word is stored on a rising `wclk` edge only when all three hold: `wen1_n` is 0, `wen2_ld` is 1, and `full_n` is 1. A low `wen2_ld` blocks writes in both modes.
- R2: A word is read on a rising `rclk` edge only when all of the following hold:
  - `ren1_n` and `ren2_n` are both 0;
  - `empty_n` is 1;
  - in load mode, `wen2_ld` is 1.
  With only one read enable low, nothing is read.
- R3: The level of `wen2_ld` while `rst_n` is 0 selects the mode until the next reset. A 1 selects two-enable mode, where a low `wen2_ld` does not affect reads. A 0 selects load mode, where a low `wen2_ld` suppresses both writes and reads.
- R4: Words come out in the order they were written. `rdata` takes the new word on the read edge and keeps it until the next read.
- R5: Once the pointers have settled, `empty_n` is 0 exactly when no words are held. `aempty_n` is 0 exactly when the count is at most `ae_offset`. Both change only on `rclk` edges.
- R6: Once the pointers have settled, `full_n` is 0 exactly when the count equals 2^AW. `afull_n` is 0 exactly when the count is at least 2^AW minus `af_offset`. Both change only on `wclk` edges.
- R7: Reset empties the buffer and sets the outputs as follows: `rdata` = 0, `empty_n` = 0, `aempty_n` = 0, `full_n` = 1, `afull_n` = 1.
- R8: Write attempts while the buffer is full are discarded. Contents already stored are not disturbed.
- R9: Read attempts while the buffer is empty leave `rdata` holding the last word read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write clock |
| rclk | input | 1 | Read clock |
| rst_n | input | 1 | Active-low reset, shared by both domains |
| wdata | input | DW | Write data |
| wen1_n | input | 1 | Active-low write enable |
| wen2_ld | input | 1 | Second write enable in two-enable mode, or load control in load mode |
| ren1_n | input | 1 | Active-low read enable, first of two |
| ren2_n | input | 1 | Active-low read enable, second of two |
| ae_offset | input | AW | Nearly-empty threshold n |
| af_offset | input | AW | Nearly-full threshold m |
| rdata | output | DW | Registered read data |
| empty_n | output | 1 | Low when empty |
| full_n | output | 1 | Low when full |
| aempty_n | output | 1 | Low when n or fewer words are held |
| afull_n | output | 1 | Low when free space is m or less |

## Verification
The bench sweeps every fill level from empty to completely full, under several threshold pairs that include zero offsets. A design with an off-by-one in the comparisons would flip a nearly flag one word early or late, or would treat n and m with the same boundary rule.

At the full level, extra writes are attempted and the whole contents are then read back. Any overflow that overwrites the oldest word shows up as a data mismatch.

The bench also checks the following cases:
- Reads on an empty buffer: a design that lets these through would change `rdata`.
- A read with a single enable low: a design that wrongly accepts it would drain a word.
- Each mode chosen at reset, with `wen2_ld` low outside reset:
  - in load mode, a read pulse must not drain a word;
  - in two-enable mode, reads must still drain words.
  A design that mixes the modes up fails one of these two.

// File: rtl/twin_clock_fifo.sv
module twin_clock_fifo #(
  parameter int DW = 9,
  parameter int AW = 5
) (
  input  logic          wclk,
  input  logic          rclk,
  input  logic          rst_n,
  input  logic [DW-1:0] wdata,
  input  logic          wen1_n,
  input  logic          wen2_ld,
  input  logic          ren1_n,
  input  logic          ren2_n,
  input  logic [AW-1:0] ae_offset,
  input  logic [AW-1:0] af_offset,
  output logic [DW-1:0] rdata,
  output logic          empty_n,
  output logic          full_n,
  output logic          aempty_n,
  output logic          afull_n
);
  localparam int PW = AW + 1;
  localparam int DEPTH = 1 << AW;
  localparam logic [PW-1:0] CAP = PW'(DEPTH);

  function automatic logic [PW-1:0] gray2bin(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  logic [DW-1:0] mem [DEPTH];
  logic two_en;
  logic [PW-1:0] wbin, wgray, rgs1, rgs2, wbin_nx, wlevel;
  logic [PW-1:0] rbin, rgray, wgs1, wgs2, rbin_nx, rlevel;
  logic wr, rd;

  always_ff @(posedge rclk)
    if (!rst_n) two_en <= wen2_ld;

  assign wr = !wen1_n && wen2_ld && full_n;
  assign rd = !ren1_n && !ren2_n && empty_n && (two_en || wen2_ld);

  assign wbin_nx = wbin + PW'(wr);
  assign wlevel  = wbin_nx - gray2bin(rgs2);
  assign rbin_nx = rbin + PW'(rd);
  assign rlevel  = gray2bin(wgs2) - rbin_nx;

  always_ff @(posedge wclk)
    if (wr) mem[wbin[AW-1:0]] <= wdata;

  always_ff @(posedge wclk or negedge rst_n)
    if (!rst_n) begin
      wbin    <= '0;
      wgray   <= '0;
      rgs1    <= '0;
      rgs2    <= '0;
      full_n  <= 1'b1;
      afull_n <= 1'b1;
    end else begin
      wbin    <= wbin_nx;
      wgray   <= wbin_nx ^ (wbin_nx >> 1);
      rgs1    <= rgray;
      rgs2    <= rgs1;
      full_n  <= wlevel != CAP;
      afull_n <= wlevel < (CAP - {1'b0, af_offset});
    end

  always_ff @(posedge rclk or negedge rst_n)
    if (!rst_n) begin
      rbin     <= '0;
      rgray    <= '0;
      wgs1     <= '0;
      wgs2     <= '0;
      rdata    <= '0;
      empty_n  <= 1'b0;
      aempty_n <= 1'b0;
    end else begin
      rbin     <= rbin_nx;
      rgray    <= rbin_nx ^ (rbin_nx >> 1);
      wgs1     <= wgray;
      wgs2     <= wgs1;
      if (rd) rdata <= mem[rbin[AW-1:0]];
      empty_n  <= rlevel != '0;
      aempty_n <= rlevel > {1'b0, ae_offset};
    end
endmodule

// File: rtl/twin_clock_fifo_chk.sv
module twin_clock_fifo_chk #(
  parameter int DW = 9,
  parameter int PW = 6
) (
  input logic          wclk,
  input logic          rclk,
  input logic          rst_n,
  input logic          full_n,
  input logic          empty_n,
  input logic          afull_n,
  input logic          aempty_n,
  input logic [DW-1:0] rdata,
  input logic [PW-1:0] wbin,
  input logic [PW-1:0] rbin
);
  a_r8_no_write_when_full: assert property (@(posedge wclk) disable iff (!rst_n)
    !full_n |=> wbin == $past(wbin));

  a_r9_no_read_when_empty: assert property (@(posedge rclk) disable iff (!rst_n)
    !empty_n |=> (rbin == $past(rbin)) && (rdata == $past(rdata)));

  a_r1_single_step: assert property (@(posedge wclk) disable iff (!rst_n)
    PW'(wbin - $past(wbin)) <= PW'(1));

  a_r2_single_step: assert property (@(posedge rclk) disable iff (!rst_n)
    PW'(rbin - $past(rbin)) <= PW'(1));

  a_r6_full_is_afull: assert property (@(posedge wclk) disable iff (!rst_n)
    !full_n |-> !afull_n);

  a_r5_empty_is_aempty: assert property (@(posedge rclk) disable iff (!rst_n)
    !empty_n |-> !aempty_n);
endmodule

bind twin_clock_fifo twin_clock_fifo_chk #(.DW(DW), .PW(AW + 1)) u_chk (
  .wclk(wclk), .rclk(rclk), .rst_n(rst_n), .full_n(full_n), .empty_n(empty_n),
  .afull_n(afull_n), .aempty_n(aempty_n), .rdata(rdata), .wbin(wbin), .rbin(rbin)
);

// File: tb/sim_twin_clock_fifo.sv
`timescale 1ns/1ps
module sim_twin_clock_fifo;
  localparam int DW = 9;
  localparam int AW = 5;
  localparam int DEPTH = 1 << AW;

  logic wclk = 0, rclk = 0, rst_n = 0;
  logic [DW-1:0] wdata = '0;
  logic wen1_n = 1, wen2_ld = 1, ren1_n = 1, ren2_n = 1;
  logic [AW-1:0] ae_offset = 7, af_offset = 7;
  logic [DW-1:0] rdata;
  logic empty_n, full_n, aempty_n, afull_n;
  int checks = 0, errors = 0;
  bit done = 0;

  always #4 wclk = ~wclk;
  initial begin #3; forever #4 rclk = ~rclk; end

  twin_clock_fifo #(.DW(DW), .AW(AW)) u0 (
    .wclk(wclk), .rclk(rclk), .rst_n(rst_n), .wdata(wdata), .wen1_n(wen1_n),
    .wen2_ld(wen2_ld), .ren1_n(ren1_n), .ren2_n(ren2_n), .ae_offset(ae_offset),
    .af_offset(af_offset), .rdata(rdata), .empty_n(empty_n), .full_n(full_n),
    .aempty_n(aempty_n), .afull_n(afull_n)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_reset(input logic mode);
    @(negedge wclk);
    rst_n = 0; wen2_ld = mode; wen1_n = 1; ren1_n = 1; ren2_n = 1;
    repeat (4) @(negedge rclk);
    repeat (2) @(negedge wclk);
    rst_n = 1;
    repeat (3) @(negedge wclk);
  endtask

  task automatic do_write(input logic [DW-1:0] d);
    @(negedge wclk); wdata = d; wen1_n = 0;
    @(negedge wclk); wen1_n = 1;
  endtask

  task automatic do_read(input logic e1, input logic e2);
    @(negedge rclk); ren1_n = e1; ren2_n = e2;
    @(negedge rclk); ren1_n = 1; ren2_n = 1;
  endtask

  task automatic settle();
    repeat (8) @(negedge wclk);
    repeat (8) @(negedge rclk);
  endtask

  function automatic logic [DW-1:0] pat(input int k, input int i);
    return DW'((k * 7 + i * 5 + 1) % 512);
  endfunction

  initial begin
    #1600000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int nl[3] = '{7, 0, 13};
    int ml[3] = '{7, 0, 20};
    do_reset(1);
    chk("R7 rdata", rdata, 0);
    chk("R7 empty_n", empty_n, 0);
    chk("R7 aempty_n", aempty_n, 0);
    chk("R7 full_n", full_n, 1);
    chk("R7 afull_n", afull_n, 1);

    for (int p = 0; p < 3; p++) begin
      for (int k = 0; k <= DEPTH; k++) begin
        ae_offset = AW'(nl[p]); af_offset = AW'(ml[p]);
        do_reset(1);
        for (int i = 0; i < k; i++) do_write(pat(k, i));
        if (k == DEPTH) for (int i = 0; i < 3; i++) do_write(~pat(k, i));
        settle();
        chk("R5 empty_n level", empty_n, int'(k != 0));
        chk("R5 aempty_n level", aempty_n, int'(k > nl[p]));
        chk("R6 full_n level", full_n, int'(k != DEPTH));
        chk("R6 afull_n level", afull_n, int'(k < DEPTH - ml[p]));
        for (int i = 0; i < k; i++) begin
          do_read(0, 0);
          chk(k == DEPTH ? "R8 data after overflow" : "R4 order", rdata, pat(k, i));
        end
        settle();
        chk("R5 drained", empty_n, 0);
        do_read(0, 0); do_read(0, 0);
        chk("R9 hold on empty", rdata, k == 0 ? 0 : pat(k, k - 1));
      end
    end
    ae_offset = 7; af_offset = 7;

    do_reset(1);
    wen2_ld = 0; do_write(9'h033); settle();
    chk("R1 wen2 low blocks write", empty_n, 0);
    wen2_ld = 1; do_write(9'h044); do_write(9'h066); settle();
    wen2_ld = 0; do_read(0, 0);
    chk("R3 two-enable mode read ok", rdata, 9'h044);
    wen2_ld = 1;
    do_read(0, 1);
    chk("R2 ren1 only", rdata, 9'h044);
    do_read(1, 0);
    chk("R2 ren2 only", rdata, 9'h044);
    do_read(0, 0);
    chk("R2 both enables", rdata, 9'h066);

    do_reset(0);
    do_write(9'h055); settle();
    chk("R3 load mode blocks write", empty_n, 0);
    wen2_ld = 1; do_write(9'h011); do_write(9'h022); settle();
    chk("R3 load mode write via wen1", empty_n, 1);
    wen2_ld = 0; do_read(0, 0);
    chk("R3 load mode blocks read", rdata, 0);
    wen2_ld = 1; do_read(0, 0);
    chk("R3 load mode read", rdata, 9'h011);
    do_reset(1);
    chk("R7 rdata cleared", rdata, 0);
    chk("R7 empty after data", empty_n, 0);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule